// File: doc/BRIEF.md
# Programmable-Format Asynchronous Serial Transmitter

This block turns one byte at a time into an asynchronous serial frame on a single output line. A six-bit format word chooses the number of data bits (5 to 8), whether a parity bit follows the data, how that parity bit is formed (odd, even or held at a fixed level), and the stop length (one bit, one and a half bits or two bits). Bytes come in through a valid/ready handshake. All bit timing comes from a free-running oversample strobe, `os_tick`, supplied by an external baud generator at sixteen pulses per bit time.

On an accepted byte, the block latches both the byte and the format word. It then sends a low start bit, the data bits least significant first, the optional parity bit, and a high stop period. When the stop period ends it returns to idle. The line rests high between frames. `tx_empty` reports that no frame is being sent. A new byte is accepted only while idle, so the format and the data cannot change a frame that is already being sent.

Top module: `async_tx_fmt`

## Requirements
- R1: After a synchronous reset, and whenever no frame is in progress, `txd` is 1, `tx_ready` is 1 and `tx_empty` is 1.
- R2: A byte is accepted on a clock edge where `tx_valid` and `tx_ready` are both 1. From the next cycle until the frame ends, `tx_ready` and `tx_empty` are 0, and `tx_valid` is ignored.
- R3: A frame starts with a low start bit in the cycle after acceptance. The data bits follow least significant bit first. `fmt_cfg[1:0]` sets the data bit count: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Unused upper data bits are not sent.
- R4: Timing advances only on cycles where `os_tick` is 1. The start bit, each data bit and the parity bit each last exactly 16 ticks.
- R5: When `fmt_cfg[3]` is 1, one parity bit is sent straight after the last data bit. When it is 0, no parity bit is sent.
- R6: With parity on and `fmt_cfg[5]` = 0, `fmt_cfg[4]` = 0 makes the count of ones over the sent data bits plus the parity bit odd, and `fmt_cfg[4]` = 1 makes that count even.
- R7: With parity on and `fmt_cfg[5]` = 1, the parity bit is 1 when `fmt_cfg[4]` = 0 and 0 when `fmt_cfg[4]` = 1, whatever the data.
- R8: The stop period holds `txd` at 1. It lasts 16 ticks when `fmt_cfg[2]` = 0, 24 ticks when `fmt_cfg[2]` = 1 with 5 data bits, and 32 ticks when `fmt_cfg[2]` = 1 with 6, 7 or 8 data bits.
- R9: The format word and data byte are sampled at acceptance. Changing `fmt_cfg` or `tx_data` during a frame does not alter that frame.
- R10: `tx_empty` and `tx_ready` return to 1 on the clock edge that consumes the last tick of the stop period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Oversample strobe, 16 per bit time |
| fmt_cfg | input | 6 | Frame format word |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Byte offered |
| tx_ready | output | 1 | Byte can be accepted |
| txd | output | 1 | Serial line output |
| tx_empty | output | 1 | No frame in progress |

## Verification
The start bit appears on `txd` in the cycle right after the accepting edge. Every later bit boundary falls on the edge that consumes the 16th tick of the current bit. `tx_empty` rises on the edge that consumes the final stop tick. The bench therefore does not count clock cycles. It counts the oversample ticks the design has consumed since acceptance, drives each tick at a falling edge, and samples on the next falling edge. Data and parity are checked at tick 8 of each bit. The stop length is checked at the tick just before the expected end and at the tick of the expected end, so a stop period that is too short or too long shows up as a failure. Strobe spacings of one, two and three cycles are used, so bit timing cannot rely on the clock rate.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;

    localparam int CFG_W    = 6;
    localparam int WORD_MAX = 8;
    localparam int WORD_MIN = 5;
    localparam int IDX_W    = $clog2(WORD_MAX);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } tx_state_e;

    typedef enum logic [1:0] {
        STOP_ONE,
        STOP_HALF,
        STOP_TWO
    } stop_len_e;

    typedef struct packed {
        logic [1:0] len_code;
        logic       par_en;
        logic       par_even;
        logic       par_force;
        stop_len_e  stop_len;
    } frame_fmt_t;

    function automatic frame_fmt_t decode_fmt(input logic [CFG_W-1:0] cfg);
        frame_fmt_t f;
        f.len_code  = cfg[1:0];
        f.par_en    = cfg[3];
        f.par_even  = cfg[4];
        f.par_force = cfg[5];
        if (!cfg[2])
            f.stop_len = STOP_ONE;
        else if (cfg[1:0] == 2'b00)
            f.stop_len = STOP_HALF;
        else
            f.stop_len = STOP_TWO;
        return f;
    endfunction

    function automatic logic [IDX_W-1:0] last_index(input logic [1:0] len_code);
        return IDX_W'(WORD_MIN - 1) + IDX_W'(len_code);
    endfunction

endpackage

// File: rtl/tx_bit_timer.sv
module tx_bit_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] last_cnt,
    output logic             bit_done
);

    logic [CNT_W-1:0] cnt;

    assign bit_done = run && tick && (cnt == last_cnt);

    always_ff @(posedge clk) begin
        if (rst || !run || bit_done)
            cnt <= '0;
        else if (tick)
            cnt <= cnt + 1'b1;
    end

    // R8: the tick count never runs past the programmed period length
    a_r8_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt <= last_cnt));

endmodule

// File: rtl/tx_parity_calc.sv
module tx_parity_calc
    import async_tx_pkg::*;
#(
    parameter int W = WORD_MAX
) (
    input  logic [W-1:0] data,
    input  frame_fmt_t   fmt,
    output logic         par_bit
);

    logic [W-1:0] masked;
    logic [IDX_W-1:0] top_idx;

    assign top_idx = last_index(fmt.len_code);

    always_comb begin
        for (int i = 0; i < W; i++)
            masked[i] = data[i] && (IDX_W'(i) <= top_idx);
    end

    always_comb begin
        if (fmt.par_force)
            par_bit = ~fmt.par_even;
        else if (fmt.par_even)
            par_bit = ^masked;
        else
            par_bit = ~^masked;
    end

endmodule

// File: rtl/async_tx_fmt.sv
module async_tx_fmt
    import async_tx_pkg::*;
#(
    parameter int OS_RATE = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                os_tick,
    input  logic [CFG_W-1:0]    fmt_cfg,
    input  logic [WORD_MAX-1:0] tx_data,
    input  logic                tx_valid,
    output logic                tx_ready,
    output logic                txd,
    output logic                tx_empty
);

    localparam int CNT_W = $clog2(2 * OS_RATE);
    localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(OS_RATE - 1);
    localparam logic [CNT_W-1:0] LAST_HALF = CNT_W'(OS_RATE + OS_RATE / 2 - 1);
    localparam logic [CNT_W-1:0] LAST_TWO  = CNT_W'(2 * OS_RATE - 1);

    tx_state_e          state;
    frame_fmt_t         fmt_q;
    frame_fmt_t         fmt_in;
    logic [WORD_MAX-1:0] shreg;
    logic [IDX_W-1:0]   bit_idx;
    logic               par_q;
    logic               par_in;
    logic               accept;
    logic               bit_done;
    logic [CNT_W-1:0]   period_last;

    assign fmt_in   = decode_fmt(fmt_cfg);
    assign accept   = tx_valid && (state == ST_IDLE);
    assign tx_ready = (state == ST_IDLE);
    assign tx_empty = (state == ST_IDLE);

    tx_parity_calc #(.W(WORD_MAX)) par_i (
        .data    (tx_data),
        .fmt     (fmt_in),
        .par_bit (par_in)
    );

    always_comb begin
        period_last = LAST_BIT;
        if (state == ST_STOP) begin
            case (fmt_q.stop_len)
                STOP_HALF: period_last = LAST_HALF;
                STOP_TWO:  period_last = LAST_TWO;
                default:   period_last = LAST_BIT;
            endcase
        end
    end

    tx_bit_timer #(.CNT_W(CNT_W)) timer_i (
        .clk      (clk),
        .rst      (rst),
        .run      (state != ST_IDLE),
        .tick     (os_tick),
        .last_cnt (period_last),
        .bit_done (bit_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            fmt_q   <= decode_fmt('0);
            shreg   <= '0;
            bit_idx <= '0;
            par_q   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (accept) begin
                    state <= ST_START;
                    fmt_q <= fmt_in;
                    shreg <= tx_data;
                    par_q <= par_in;
                end
                ST_START: if (bit_done) begin
                    state   <= ST_DATA;
                    bit_idx <= '0;
                end
                ST_DATA: if (bit_done) begin
                    shreg   <= shreg >> 1;
                    bit_idx <= bit_idx + 1'b1;
                    if (bit_idx == last_index(fmt_q.len_code))
                        state <= fmt_q.par_en ? ST_PAR : ST_STOP;
                end
                ST_PAR:  if (bit_done) state <= ST_STOP;
                ST_STOP: if (bit_done) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        case (state)
            ST_START: txd = 1'b0;
            ST_DATA:  txd = shreg[0];
            ST_PAR:   txd = par_q;
            default:  txd = 1'b1;
        endcase
    end

    // R1: an idle transmitter keeps the line high
    a_r1_idle_line_high: assert property (@(posedge clk) disable iff (rst)
        tx_ready |-> txd);

    // R2: acceptance makes the block busy on the next cycle
    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready) |=> !tx_ready && !tx_empty);

    // R3: the start bit follows acceptance immediately
    a_r3_start_low: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready) |=> !txd);

    // R4: without a tick, a frame in progress holds its line level
    a_r4_hold_no_tick: assert property (@(posedge clk) disable iff (rst)
        (!os_tick && !tx_ready) |=> $stable(txd));

    // R10: the frame ends only on a tick
    a_r10_end_on_tick: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_empty) |-> $past(os_tick));

endmodule

// File: tb/async_tx_fmt_tb_top.sv
module async_tx_fmt_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       os_tick = 1'b0;
    logic [5:0] fmt_cfg = '0;
    logic [7:0] tx_data = '0;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic       txd;
    logic       tx_empty;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    async_tx_fmt dut_i (
        .clk      (clk),
        .rst      (rst),
        .os_tick  (os_tick),
        .fmt_cfg  (fmt_cfg),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .tx_ready (tx_ready),
        .txd      (txd),
        .tx_empty (tx_empty)
    );

    // {cfg[5:0], data[7:0], tick spacing[3:0]}
    localparam int NVEC = 12;
    localparam logic [17:0] VEC [NVEC] = '{
        {6'b000000, 8'hA5, 4'd1},
        {6'b000011, 8'h3C, 4'd1},
        {6'b000001, 8'h2D, 4'd2},
        {6'b000010, 8'h5A, 4'd1},
        {6'b001011, 8'h81, 4'd1},
        {6'b011011, 8'h07, 4'd1},
        {6'b101011, 8'hFF, 4'd1},
        {6'b111011, 8'h00, 4'd2},
        {6'b000100, 8'h1F, 4'd3},
        {6'b000111, 8'hC3, 4'd1},
        {6'b011100, 8'hE6, 4'd2},
        {6'b001110, 8'hF0, 4'd1}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int stop_ticks(input logic [5:0] cfg);
        if (!cfg[2]) return 16;
        if (cfg[1:0] == 2'b00) return 24;
        return 32;
    endfunction

    function automatic logic exp_parity(input logic [5:0] cfg, input logic [7:0] d);
        logic x;
        int n;
        n = 5 + int'(cfg[1:0]);
        x = 1'b0;
        for (int i = 0; i < n; i++) x = x ^ d[i];
        if (cfg[5]) return ~cfg[4];
        if (cfg[4]) return x;
        return ~x;
    endfunction

    task automatic send_frame(input logic [5:0] cfg, input logic [7:0] dat, input int div);
        int n, np, tot, td, last, ph, b;
        logic e;
        string ptag;
        n   = 5 + int'(cfg[1:0]);
        np  = int'(cfg[3]);
        tot = 16 * (1 + n + np) + stop_ticks(cfg);
        ptag = cfg[5] ? "R7 forced parity" : "R6 parity value";
        @(negedge clk);
        check(tx_ready == 1'b1, "R1 ready before frame", int'(tx_ready), 1);
        fmt_cfg  = cfg;
        tx_data  = dat;
        tx_valid = 1'b1;
        os_tick  = 1'b0;
        @(negedge clk);
        // R9: change inputs and keep offering a byte while busy
        fmt_cfg = ~cfg;
        tx_data = ~dat;
        td = 0; last = -1; ph = 0;
        while (1) begin
            if (td != last) begin
                last = td;
                b = td / 16;
                if (td == 0) begin
                    check(tx_empty == 1'b0 && tx_ready == 1'b0, "R2 busy after accept",
                          int'(tx_empty), 0);
                    check(txd == 1'b0, "R3 start bit", int'(txd), 0);
                end
                if (td == 15)
                    check(txd == 1'b0, "R4 start lasts 16 ticks", int'(txd), 0);
                if ((td % 16) == 8 && b >= 1 && b <= n) begin
                    e = dat[b-1];
                    check(txd == e, "R3/R9 data bit", int'(txd), int'(e));
                end
                if ((td % 16) == 8 && b == n + 1) begin
                    if (np == 1) begin
                        e = exp_parity(cfg, dat);
                        check(txd == e, ptag, int'(txd), int'(e));
                    end else begin
                        check(txd == 1'b1, "R5 no parity slot", int'(txd), 1);
                    end
                end
                if (td == tot - 1) begin
                    check(txd == 1'b1, "R8 stop level", int'(txd), 1);
                    check(tx_empty == 1'b0, "R8 stop length not short", int'(tx_empty), 0);
                end
                if (td == tot) begin
                    check(tx_empty == 1'b1 && tx_ready == 1'b1, "R10 empty at frame end",
                          int'(tx_empty), 1);
                    check(txd == 1'b1, "R1 idle line", int'(txd), 1);
                end
            end
            if (td == tot) break;
            if (td >= tot - 2) tx_valid = 1'b0;
            os_tick = ((ph % div) == 0);
            ph++;
            @(negedge clk);
            if (os_tick) td++;
        end
        os_tick  = 1'b0;
        tx_valid = 1'b0;
    endtask

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: state after reset
        check(txd == 1'b1, "R1 reset txd", int'(txd), 1);
        check(tx_ready == 1'b1, "R1 reset ready", int'(tx_ready), 1);
        check(tx_empty == 1'b1, "R1 reset empty", int'(tx_empty), 1);

        for (int v = 0; v < NVEC; v++)
            send_frame(VEC[v][17:12], VEC[v][11:4], int'(VEC[v][3:0]));

        // R1: reset in the middle of a frame returns to idle
        @(negedge clk);
        fmt_cfg = 6'b001011; tx_data = 8'h00; tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0; os_tick = 1'b1;
        repeat (40) @(negedge clk);
        check(tx_empty == 1'b0, "R2 busy mid-frame", int'(tx_empty), 0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0; os_tick = 1'b0;
        check(txd == 1'b1 && tx_ready == 1'b1 && tx_empty == 1'b1,
              "R1 reset mid-frame", int'(txd), 1);

        // a clean frame after that reset
        send_frame(6'b010100, 8'h13, 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule